// File: doc/BRIEF.md
# Barrier Synchronization Wave Combiner

This block sits inside one switch element of an on-chip network that carries ordinary data messages together with special synchronization markers. Every source sends its marker only after all of its messages for the current superstep are out. The combiner records, input by input, which links have already delivered their marker for the running superstep. Data from links that have not yet delivered a marker is routed into per-output queues. A queue takes a message only while it has room.

Once every input has delivered its marker, the block fires the barrier wave. Each output first drains whatever data is already queued for it. It then presents exactly one marker. When every output has handed its marker on, the per-input record is cleared and a superstep counter advances by one. The block is then ready for the next superstep.

Traffic of the next superstep must not overtake the barrier. For this reason, data arriving on an input that has already delivered its marker is held at that input until the wave has completed. A second marker on an input that is already marked is taken off the link and discarded, and an error pulse flags it.

Top module: `wave_combiner`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no output is valid, `err_dup` is 0, `superstep` is 0 and no input is marked.
- R2: A data message (valid with `in_sync`=0) on an unmarked input whose destination field names output j is accepted only while queue j holds fewer than QD entries. Output j delivers the accepted messages in arrival order with `out_sync`=0.
- R3: When several unmarked inputs offer data to the same output in one cycle, only the lowest-numbered of them is considered, and the others see `in_ready`=0.
- R4: A marker on an unmarked input is accepted (`in_ready`=1) and marks that input. From then on, data on that input sees `in_ready`=0 until the wave completes.
- R5: An output presents a marker (`out_valid`=1, `out_sync`=1) only while all inputs are marked. Each output presents exactly one marker per wave.
- R6: An output presents its marker only after every data message queued for it has been delivered.
- R7: From the cycle after the last input is marked until the last output marker is taken, `in_ready` is 0 on every input.
- R8: In the cycle in which the last outstanding output marker is taken, all input marks clear. `superstep` then rises by exactly one and wraps at 2^CW.
- R9: A marker on an input that is already marked is accepted and discarded. `err_dup` is 1 in the following cycle, and neither the marks nor `superstep` change because of it.
- R10: An output that is valid and not ready keeps `out_valid`, `out_sync` and `out_data` unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N_IN | Per-input message present |
| in_sync | input | N_IN | Per-input: message is a synchronization marker |
| in_dst | input | N_IN*DSTW | Per-input destination output index (data only) |
| in_data | input | N_IN*DW | Per-input data payload |
| in_ready | output | N_IN | Per-input message taken this cycle |
| out_valid | output | N_OUT | Per-output message present |
| out_sync | output | N_OUT | Per-output: message is a marker |
| out_data | output | N_OUT*DW | Per-output payload, zero for a marker |
| out_ready | input | N_OUT | Per-output downstream acceptance |
| err_dup | output | 1 | One-cycle pulse after a duplicate marker |
| superstep | output | CW | Count of completed waves |

## Verification
The bench builds the block with three inputs, two outputs, queues only two entries deep and a three-bit superstep counter. The shallow queues fill within a few cycles, so the space check and the data-before-marker ordering come up constantly. Three inputs contending for two outputs exercise the lowest-index rule. The narrow counter wraps several times within one run. Heavy marker traffic phases make duplicate markers and back-to-back waves frequent.

// File: rtl/wave_pkg.sv
package wave_pkg;

  typedef enum logic {
    PH_COLLECT = 1'b0,
    PH_EMIT    = 1'b1
  } phase_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/wave_fifo.sv
module wave_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [DW-1:0]   mem [DEPTH];
  logic [PW-1:0]   wp_q, wp_d, rp_q, rp_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNTW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

endmodule

// File: rtl/wave_tracker.sv
module wave_tracker
  import wave_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int CW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  sync_acc,
  input  logic             dup_seen,
  input  logic [N_OUT-1:0] sync_taken,
  output logic [N_IN-1:0]  marked,
  output logic [N_OUT-1:0] pend,
  output logic             emit,
  output logic [CW-1:0]    cnt,
  output logic             err_dup
);
  phase_e           ph_q, ph_d;
  logic [N_IN-1:0]  mark_q, mark_d;
  logic [N_OUT-1:0] pend_q, pend_d;
  logic [CW-1:0]    cnt_q;
  logic             cnt_en;
  logic             err_q;

  always_comb begin
    ph_d   = ph_q;
    mark_d = mark_q | sync_acc;
    pend_d = pend_q;
    cnt_en = 1'b0;
    case (ph_q)
      PH_COLLECT: begin
        if (&mark_q) begin
          ph_d   = PH_EMIT;
          pend_d = '1;
        end
      end
      PH_EMIT: begin
        pend_d = pend_q & ~sync_taken;
        if (pend_d == '0) begin
          ph_d   = PH_COLLECT;
          mark_d = '0;
          cnt_en = 1'b1;
        end
      end
      default: ph_d = PH_COLLECT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_COLLECT;
      mark_q <= '0;
      pend_q <= '0;
      err_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      mark_q <= mark_d;
      pend_q <= pend_d;
      err_q  <= dup_seen;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_q + 1'b1;
  end

  assign marked  = mark_q;
  assign pend    = pend_q;
  assign emit    = (ph_q == PH_EMIT);
  assign cnt     = cnt_q;
  assign err_dup = err_q;

endmodule

// File: rtl/wave_combiner.sv
module wave_combiner
  import wave_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int DW    = 16,
  parameter int QD    = 4,
  parameter int CW    = 16,
  localparam int DSTW = idx_w(N_OUT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_IN-1:0]      in_valid,
  input  logic [N_IN-1:0]      in_sync,
  input  logic [N_IN*DSTW-1:0] in_dst,
  input  logic [N_IN*DW-1:0]   in_data,
  output logic [N_IN-1:0]      in_ready,
  output logic [N_OUT-1:0]     out_valid,
  output logic [N_OUT-1:0]     out_sync,
  output logic [N_OUT*DW-1:0]  out_data,
  input  logic [N_OUT-1:0]     out_ready,
  output logic                 err_dup,
  output logic [CW-1:0]        superstep
);
  logic [N_IN-1:0]  marked;
  logic [N_OUT-1:0] pend;
  logic             emit;
  logic [N_IN-1:0]  sync_new, sync_dup, data_req, grant;
  logic [N_OUT-1:0] push, pop, q_empty, q_full, sync_taken;
  logic [DW-1:0]    q_din  [N_OUT];
  logic [DW-1:0]    q_dout [N_OUT];

  always_comb begin
    sync_new = in_valid & in_sync & ~marked & {N_IN{~emit}};
    sync_dup = in_valid & in_sync & marked & {N_IN{~emit}};
    data_req = in_valid & ~in_sync & ~marked & {N_IN{~emit}};
  end

  always_comb begin : arb
    logic seen;
    grant = '0;
    push  = '0;
    seen  = 1'b0;
    for (int j = 0; j < N_OUT; j++) begin
      q_din[j] = '0;
      seen     = 1'b0;
      for (int i = 0; i < N_IN; i++) begin
        if (!seen && data_req[i] && (in_dst[i*DSTW +: DSTW] == DSTW'(j))) begin
          seen = 1'b1;
          if (!q_full[j]) begin
            grant[i] = 1'b1;
            push[j]  = 1'b1;
            q_din[j] = in_data[i*DW +: DW];
          end
        end
      end
    end
  end

  assign in_ready = grant | sync_new | sync_dup;

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    wave_fifo #(
      .DW   (DW),
      .DEPTH(QD)
    ) u_q (
      .clk  (clk),
      .rst_n(rst_n),
      .push (push[j]),
      .din  (q_din[j]),
      .pop  (pop[j]),
      .dout (q_dout[j]),
      .empty(q_empty[j]),
      .full (q_full[j])
    );
    assign pop[j]                = out_ready[j] && !q_empty[j];
    assign sync_taken[j]         = out_ready[j] && q_empty[j] && pend[j];
    assign out_valid[j]          = !q_empty[j] || pend[j];
    assign out_sync[j]           = q_empty[j] && pend[j];
    assign out_data[j*DW +: DW]  = q_empty[j] ? '0 : q_dout[j];
  end

  wave_tracker #(
    .N_IN (N_IN),
    .N_OUT(N_OUT),
    .CW   (CW)
  ) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_acc  (sync_new),
    .dup_seen  (|sync_dup),
    .sync_taken(sync_taken),
    .marked    (marked),
    .pend      (pend),
    .emit      (emit),
    .cnt       (superstep),
    .err_dup   (err_dup)
  );

endmodule

// File: rtl/wave_combiner_chk.sv
module wave_combiner_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int DW    = 16,
  parameter int CW    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_IN-1:0]     in_valid,
  input logic [N_IN-1:0]     in_sync,
  input logic [N_IN-1:0]     in_ready,
  input logic [N_OUT-1:0]    out_valid,
  input logic [N_OUT-1:0]    out_sync,
  input logic [N_OUT*DW-1:0] out_data,
  input logic [N_OUT-1:0]    out_ready,
  input logic                err_dup,
  input logic [CW-1:0]       superstep,
  input logic [N_IN-1:0]     marked
);

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    assert_hold_marked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (marked[i] && in_valid[i] && !in_sync[i]) |-> !in_ready[i]);
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_o
    assert_marker_all_in_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[j] && out_sync[j]) |-> (&marked));
    assert_out_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[j] && !out_ready[j]) |=>
        (out_valid[j] && $stable(out_sync[j]) && $stable(out_data[j*DW +: DW])));
  end

  assert_inputs_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(out_valid & out_sync)) |-> (in_ready == '0));

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (superstep != $past(superstep)) |-> (superstep == CW'($past(superstep) + 1'b1)));

  assert_dup_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_dup |-> $past(|(in_valid & in_sync & in_ready & marked)));

endmodule

bind wave_combiner wave_combiner_chk #(
  .N_IN (N_IN),
  .N_OUT(N_OUT),
  .DW   (DW),
  .CW   (CW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_sync  (in_sync),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_sync (out_sync),
  .out_data (out_data),
  .out_ready(out_ready),
  .err_dup  (err_dup),
  .superstep(superstep),
  .marked   (marked)
);

// File: tb/sim_wave_combiner.sv
`timescale 1ns/1ps
module sim_wave_combiner;
  localparam int N_IN  = 3;
  localparam int N_OUT = 2;
  localparam int DW    = 8;
  localparam int QD    = 2;
  localparam int CW    = 3;
  localparam int DSTW  = 1;

  logic                 clk;
  logic                 rst_n;
  logic [N_IN-1:0]      in_valid, in_sync, in_ready;
  logic [N_IN*DSTW-1:0] in_dst;
  logic [N_IN*DW-1:0]   in_data;
  logic [N_OUT-1:0]     out_valid, out_sync, out_ready;
  logic [N_OUT*DW-1:0]  out_data;
  logic                 err_dup;
  logic [CW-1:0]        superstep;

  wave_combiner #(.N_IN(N_IN), .N_OUT(N_OUT), .DW(DW), .QD(QD), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync),
    .in_dst(in_dst), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_sync(out_sync), .out_data(out_data),
    .out_ready(out_ready), .err_dup(err_dup), .superstep(superstep)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int waves = 0;
  bit finished = 1'b0;

  // behavioural reference state
  logic [DW-1:0]    mq [N_OUT][$];
  logic [N_IN-1:0]  m_mark;
  logic [N_OUT-1:0] m_pend;
  logic [N_OUT-1:0] hold_prev;
  bit               m_emit;
  bit               m_err;
  int               m_cnt;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int j = 0; j < N_OUT; j++) mq[j].delete();
    m_mark = '0; m_pend = '0; m_emit = 0; m_err = 0; m_cnt = 0; hold_prev = '0;
  endtask

  // one cycle: inputs already driven after a falling edge
  task automatic cycle();
    logic [N_IN-1:0]  e_rdy, g;
    logic [N_OUT-1:0] e_v, e_s;
    bit               dup;
    bit               seen;
    int               d;
    string            tag;
    #2;
    g = '0; e_rdy = '0; dup = 0;
    for (int j = 0; j < N_OUT; j++) begin
      seen = 0;
      for (int i = 0; i < N_IN; i++) begin
        d = int'(in_dst[i]);
        if (!m_emit && in_valid[i] && !in_sync[i] && !m_mark[i] && d == j && !seen) begin
          seen = 1;
          if (mq[j].size() < QD) g[i] = 1'b1;
        end
      end
    end
    for (int i = 0; i < N_IN; i++) begin
      if (!m_emit && in_valid[i] && in_sync[i]) begin
        e_rdy[i] = 1'b1;
        if (m_mark[i]) dup = 1;
      end
      if (g[i]) e_rdy[i] = 1'b1;
    end
    for (int i = 0; i < N_IN; i++) begin
      if (m_emit) tag = "R7";
      else if (in_valid[i] && in_sync[i]) tag = m_mark[i] ? "R9" : "R4";
      else if (m_mark[i]) tag = "R4";
      else tag = "R3";
      if (!m_emit && in_valid[i] && !in_sync[i] && !m_mark[i] && e_rdy[i] == 1'b0 && tag == "R3"
          && mq[int'(in_dst[i])].size() >= QD) tag = "R2";
      chk(in_ready[i] === e_rdy[i], tag, in_ready[i], e_rdy[i]);
    end
    for (int j = 0; j < N_OUT; j++) begin
      e_v[j] = (mq[j].size() > 0) || m_pend[j];
      e_s[j] = (mq[j].size() == 0) && m_pend[j];
      chk(out_valid[j] === e_v[j], "R5", out_valid[j], e_v[j]);
      chk(out_sync[j] === e_s[j], "R6", out_sync[j], e_s[j]);
      if (mq[j].size() > 0)
        chk(out_data[j*DW +: DW] === mq[j][0], hold_prev[j] ? "R10" : "R2",
            out_data[j*DW +: DW], mq[j][0]);
    end
    chk(err_dup === m_err, "R9", err_dup, m_err);
    chk(int'(superstep) == m_cnt, "R8", superstep, m_cnt);
    @(posedge clk);
    // reference update
    hold_prev = out_valid & ~out_ready;
    m_err = dup;
    for (int j = 0; j < N_OUT; j++) begin
      if (out_ready[j]) begin
        if (mq[j].size() > 0) void'(mq[j].pop_front());
        else if (m_pend[j]) m_pend[j] = 1'b0;
      end
    end
    for (int i = 0; i < N_IN; i++)
      if (g[i]) mq[int'(in_dst[i])].push_back(in_data[i*DW +: DW]);
    if (!m_emit) begin
      if (&m_mark) begin
        m_emit = 1;
        m_pend = '1;
      end else begin
        for (int i = 0; i < N_IN; i++)
          if (in_valid[i] && in_sync[i]) m_mark[i] = 1'b1;
      end
    end else if (m_pend == '0) begin
      m_emit = 0;
      m_mark = '0;
      m_cnt  = (m_cnt + 1) % (1 << CW);
      waves++;
    end
  endtask

  task automatic run(input int n, input int pv, input int ps, input int pr);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      for (int i = 0; i < N_IN; i++) begin
        in_valid[i] = ($urandom_range(99) < pv);
        in_sync[i]  = ($urandom_range(99) < ps);
        in_dst[i]   = 1'($urandom_range(1));
        in_data[i*DW +: DW] = 8'($urandom_range(255));
      end
      for (int j = 0; j < N_OUT; j++) out_ready[j] = ($urandom_range(99) < pr);
      cycle();
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = '0; in_sync = '0; in_dst = '0; in_data = '0; out_ready = '0;
    model_reset();
    repeat (3) @(posedge clk);
    // R1: state under reset
    @(negedge clk);
    chk(out_valid === '0, "R1", out_valid, 0);
    chk(err_dup === 1'b0, "R1", err_dup, 0);
    chk(superstep === '0, "R1", superstep, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === '0 && out_valid === '0, "R1", {in_ready, out_valid}, 0);
    // all data, no drain: fill queues (R2, R3)
    run(12, 100, 0, 0);
    // markers everywhere with blocked outputs: duplicates and held wave (R4, R9, R6)
    run(8, 100, 100, 0);
    // drain: data then one marker per output (R6, R5, R8)
    run(12, 0, 0, 100);
    run(3000, 60, 15, 70);
    run(1500, 85, 40, 40);
    run(1500, 50, 25, 95);
    chk(waves > (1 << CW), "R8", waves, (1 << CW) + 1);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R5 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule